// File: doc/BRIEF.md
# MDIO Management Command Engine

This block drives a PHY's clause-22 serial management bus on behalf of a host that cannot reach the block's registers directly. The host sees only two ports: an address port and a data port. It reaches two internal 16-bit registers through them, a command register and a transfer-data register. Writing an address with the top bit clear fetches that internal register onto the read-data port. To store a word, the host first places the word on the data port and then writes the address with the top bit set.

Writing the command register starts one management frame. The frame is a read or a write, aimed at one register of one PHY. The engine produces the management clock from the system clock with a parameterised divider. It shifts the frame out with the data line changing on the falling clock edge, and it samples the PHY on the rising edge. When a read finishes, the captured word lands in the transfer-data register. A completion flag in the command register tells the host when the engine is idle again.

Top module: `mdio_mgmt_engine`

## Requirements
- R1: After reset the command register reads 0x4000, the transfer-data register reads 0x0000, mdc is low and mdio_oe is low.
- R2: An address-port write with bit 31 clear loads host_rdata, at the next clock edge, with the internal register at the offset in bits 30:0. The command register is at 0x14, the transfer-data register is at 0x16, and any other offset reads 0.
- R3: An address-port write with bit 31 set copies the word last written to the data port into the internal register at the given offset.
- R4: The command word fields are PHY address at bits 12:8, register number at bits 4:0, write flag at bit 13 (1 = write, 0 = read) and finished flag at bit 14. Bits 15 and 7:5 read as 0.
- R5: The finished flag reads 0 from the command write that starts a frame until the frame has ended, and then reads 1 again.
- R6: A frame is 64 management-clock periods long, sent MSB first. It consists of 32 ones, then 01, then the opcode (10 for read, 01 for write), the 5-bit PHY address, the 5-bit register number, a 2-bit turnaround (10 on a write) and 16 data bits.
- R7: While a frame runs, mdc has a period of 2*DIV_HALF system clocks. mdc is low whenever the engine is idle, and mdio_o never changes on an mdc rising edge.
- R8: On a read, mdio_oe is low from the first turnaround bit through the last data bit, so 46 of the 64 rising edges see it high. The 16 bits sampled on the data-phase rising edges become the transfer-data register.
- R9: A command-register write or a transfer-data-register write that arrives while a frame is running changes nothing.
- R10: A write frame sends, in its data phase, the transfer-data register value held when the command was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr_wr | input | 1 | Strobe for the address port |
| host_addr | input | HOST_AW | Bit HOST_AW-1: store request; lower bits: internal offset |
| host_wdata_wr | input | 1 | Strobe for the data port |
| host_wdata | input | 16 | Word staged for the next store |
| host_rdata | output | 16 | Internal register fetched by the last load request |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Drive enable for mdio_o |
| mdio_i | input | 1 | Management data in (line value) |

## Verification
The bench builds the engine with DIV_HALF = 3, which gives a 6-cycle management clock. This keeps each 64-bit frame under 400 cycles, so write frames, matched and unmatched reads, and a busy-time collision all fit in one short run. The PHY responder answers only at address 5 and leaves the line pulled high otherwise. An unmatched read therefore must return 0xFFFF. The responder records the preamble length, opcode, address fields, turnaround and write data exactly as they appear on the wire.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam int REG_W     = 16;
  localparam int FIELD_W   = 5;
  localparam int PRE_LEN   = 32;
  localparam int FRAME_LEN = PRE_LEN + 4 + 2 * FIELD_W + 2 + REG_W;
  localparam int TA_IDX    = PRE_LEN + 4 + 2 * FIELD_W;
  localparam int DATA_IDX  = TA_IDX + 2;
  localparam int OFF_CTL   = 'h14;
  localparam int OFF_DATA  = 'h16;
  localparam int BIT_WR    = 13;
  localparam int BIT_FIN   = 14;

  typedef struct packed {
    logic               wr;
    logic [FIELD_W-1:0] phy;
    logic [FIELD_W-1:0] regn;
  } mgmt_cmd_t;
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int DIV_HALF = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic mdc,
  output logic rise_tk,
  output logic fall_tk
);
  localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

  logic [CW-1:0] cnt_q;
  logic          mdc_q;
  logic          wrap;

  assign wrap    = (cnt_q == CW'(DIV_HALF - 1));
  assign rise_tk = run && wrap && !mdc_q;
  assign fall_tk = run && wrap && mdc_q;
  assign mdc     = mdc_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame_shifter.sv
module mdio_frame_shifter
  import mdio_mgmt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  mgmt_cmd_t        go_cmd,
  input  logic [REG_W-1:0] tx_data,
  input  logic             rise_tk,
  input  logic             fall_tk,
  input  logic             mdio_i,
  output logic             busy,
  output logic             mdio_o,
  output logic             mdio_oe,
  output logic             rd_done,
  output logic [REG_W-1:0] rd_value
);
  localparam int IDX_W = $clog2(FRAME_LEN);

  logic                 busy_q, wr_q, oe_q, done_q;
  logic [IDX_W-1:0]     idx_q;
  logic [FRAME_LEN-1:0] sh_q;
  logic [REG_W-1:0]     rx_q;
  logic [FRAME_LEN-1:0] frame;

  assign frame = {{PRE_LEN{1'b1}}, 2'b01,
                  go_cmd.wr ? 2'b01 : 2'b10,
                  go_cmd.phy, go_cmd.regn,
                  go_cmd.wr ? 2'b10 : 2'b00,
                  go_cmd.wr ? tx_data : {REG_W{1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      wr_q   <= 1'b0;
      oe_q   <= 1'b0;
      done_q <= 1'b0;
      idx_q  <= '0;
      sh_q   <= '0;
      rx_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (go && !busy_q) begin
        busy_q <= 1'b1;
        wr_q   <= go_cmd.wr;
        idx_q  <= '0;
        sh_q   <= frame;
        oe_q   <= 1'b1;
      end else if (busy_q) begin
        if (rise_tk && !wr_q && idx_q >= IDX_W'(DATA_IDX))
          rx_q <= {rx_q[REG_W-2:0], mdio_i};
        if (fall_tk) begin
          sh_q <= {sh_q[FRAME_LEN-2:0], 1'b0};
          if (idx_q == IDX_W'(FRAME_LEN - 1)) begin
            busy_q <= 1'b0;
            oe_q   <= 1'b0;
            done_q <= !wr_q;
          end else begin
            idx_q <= idx_q + 1'b1;
            if (!wr_q && idx_q == IDX_W'(TA_IDX - 1))
              oe_q <= 1'b0;
          end
        end
      end
    end
  end

  assign busy     = busy_q;
  assign mdio_o   = sh_q[FRAME_LEN-1];
  assign mdio_oe  = oe_q;
  assign rd_done  = done_q;
  assign rd_value = rx_q;

  // R8: line released by the engine across turnaround and data of a read
  p_read_release_r8: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !wr_q && idx_q >= IDX_W'(TA_IDX)) |-> !oe_q);
  // R7: no drive while idle
  p_idle_no_drive_r7: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> !oe_q);
endmodule

// File: rtl/mdio_host_port.sv
module mdio_host_port
  import mdio_mgmt_pkg::*;
#(
  parameter int HOST_AW = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               host_addr_wr,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic               host_wdata_wr,
  input  logic [REG_W-1:0]   host_wdata,
  output logic [REG_W-1:0]   host_rdata,
  input  logic               busy,
  input  logic               rd_done,
  input  logic [REG_W-1:0]   rd_value,
  output logic               go,
  output mgmt_cmd_t          go_cmd,
  output logic [REG_W-1:0]   tx_data
);
  localparam int OFF_W = HOST_AW - 1;

  logic [REG_W-1:0] stage_q, data_q, rdata_q, rd_mux, ctl_word;
  mgmt_cmd_t        cmd_q;
  logic             store, hit_ctl, hit_data, cmd_acc, data_acc;

  assign store    = host_addr[HOST_AW-1];
  assign hit_ctl  = host_addr[OFF_W-1:0] == OFF_W'(OFF_CTL);
  assign hit_data = host_addr[OFF_W-1:0] == OFF_W'(OFF_DATA);
  assign cmd_acc  = host_addr_wr && store && hit_ctl && !busy;
  assign data_acc = host_addr_wr && store && hit_data && !busy;

  assign go_cmd = '{wr: stage_q[BIT_WR], phy: stage_q[12:8],
                    regn: stage_q[FIELD_W-1:0]};
  assign go      = cmd_acc;
  assign tx_data = data_q;

  assign ctl_word = {1'b0, !busy, cmd_q.wr, cmd_q.phy, 3'b000, cmd_q.regn};

  always_comb begin
    rd_mux = '0;
    if (hit_ctl)  rd_mux = ctl_word;
    if (hit_data) rd_mux = data_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
      data_q  <= '0;
      rdata_q <= '0;
      cmd_q   <= '0;
    end else begin
      if (host_wdata_wr) stage_q <= host_wdata;
      if (rd_done)       data_q  <= rd_value;
      if (data_acc)      data_q  <= stage_q;
      if (cmd_acc)       cmd_q   <= go_cmd;
      if (host_addr_wr && !store) rdata_q <= rd_mux;
    end
  end

  assign host_rdata = rdata_q;

  // R5: an accepted command makes the engine busy at the next edge
  p_go_sets_busy_r5: assert property (@(posedge clk) disable iff (rst)
    go |=> busy);
  // R9: command store during a frame leaves the command untouched
  p_busy_cmd_ignored_r9: assert property (@(posedge clk) disable iff (rst)
    (host_addr_wr && store && hit_ctl && busy) |=> $stable(cmd_q));
endmodule

// File: rtl/mdio_mgmt_engine.sv
module mdio_mgmt_engine
  import mdio_mgmt_pkg::*;
#(
  parameter int HOST_AW  = 32,
  parameter int DIV_HALF = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               host_addr_wr,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic               host_wdata_wr,
  input  logic [REG_W-1:0]   host_wdata,
  output logic [REG_W-1:0]   host_rdata,
  output logic               mdc,
  output logic               mdio_o,
  output logic               mdio_oe,
  input  logic               mdio_i
);
  logic             busy, go, rd_done, rise_tk, fall_tk;
  mgmt_cmd_t        go_cmd;
  logic [REG_W-1:0] tx_data, rd_value;

  mdio_host_port #(.HOST_AW(HOST_AW)) u_host (
    .clk(clk), .rst(rst),
    .host_addr_wr(host_addr_wr), .host_addr(host_addr),
    .host_wdata_wr(host_wdata_wr), .host_wdata(host_wdata),
    .host_rdata(host_rdata),
    .busy(busy), .rd_done(rd_done), .rd_value(rd_value),
    .go(go), .go_cmd(go_cmd), .tx_data(tx_data)
  );

  mdio_clk_div #(.DIV_HALF(DIV_HALF)) u_div (
    .clk(clk), .rst(rst), .run(busy),
    .mdc(mdc), .rise_tk(rise_tk), .fall_tk(fall_tk)
  );

  mdio_frame_shifter u_shift (
    .clk(clk), .rst(rst), .go(go), .go_cmd(go_cmd), .tx_data(tx_data),
    .rise_tk(rise_tk), .fall_tk(fall_tk), .mdio_i(mdio_i),
    .busy(busy), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .rd_done(rd_done), .rd_value(rd_value)
  );

  // R7: management clock parked low while idle
  p_idle_mdc_low_r7: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdc);
  // R7: data line holds still across an mdc rising edge
  p_mdio_hold_rise_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(mdc) |-> $stable(mdio_o));
endmodule

// File: tb/mdio_mgmt_engine_bench.sv
module mdio_mgmt_engine_bench;
  localparam int AW = 32;
  localparam int DH = 3;
  localparam int MY_PHY = 5;

  logic          clk = 1'b0, rst = 1'b1;
  logic          addr_wr = 1'b0, wdata_wr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [15:0]   wdata = '0;
  logic [15:0]   rdata;
  logic          mdc, mdio_o, mdio_oe, mdio_line;
  logic          phy_drv = 1'b0, phy_bit = 1'b1;

  int checks = 0, fails = 0, rises = 0, oe_rises = 0;
  bit done_flag = 0;

  always #5 clk = ~clk;

  assign mdio_line = mdio_oe ? mdio_o : (phy_drv ? phy_bit : 1'b1);

  mdio_mgmt_engine #(.HOST_AW(AW), .DIV_HALF(DH)) u_mdio_mgmt_engine (
    .clk(clk), .rst(rst), .host_addr_wr(addr_wr), .host_addr(addr),
    .host_wdata_wr(wdata_wr), .host_wdata(wdata), .host_rdata(rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_line)
  );

  // ---------------- PHY responder ----------------
  logic [15:0] phy_regs [32];
  logic [1:0]  last_op, last_ta;
  logic [4:0]  last_phy, last_reg;
  logic [15:0] last_wdata;
  int          last_pre;

  always @(posedge mdc) begin
    rises++;
    if (mdio_oe) oe_rises++;
  end

  initial begin
    for (int i = 0; i < 32; i++) phy_regs[i] = 16'(i * 3);
    phy_regs[0] = 16'h8000;
    last_op = '0; last_ta = '0; last_phy = '0; last_reg = '0;
    last_wdata = '0; last_pre = 0;
    forever begin
      int ones;
      logic [11:0] hdr;
      logic [17:0] body;
      ones = 0;
      forever begin
        @(posedge mdc);
        if (mdio_line) ones++;
        else if (ones >= 32) break;
        else ones = 0;
      end
      @(posedge mdc);
      if (mdio_line) begin
        for (int i = 11; i >= 0; i--) begin @(posedge mdc); hdr[i] = mdio_line; end
        last_pre = ones;
        last_op  = hdr[11:10];
        last_phy = hdr[9:5];
        last_reg = hdr[4:0];
        if (hdr[11:10] == 2'b01) begin
          for (int i = 17; i >= 0; i--) begin @(posedge mdc); body[i] = mdio_line; end
          last_ta = body[17:16];
          last_wdata = body[15:0];
          if (hdr[9:5] == 5'(MY_PHY)) phy_regs[hdr[4:0]] = body[15:0];
        end else if (hdr[9:5] == 5'(MY_PHY)) begin
          @(negedge mdc);
          @(negedge mdc); phy_drv = 1'b1; phy_bit = 1'b0;
          for (int i = 15; i >= 0; i--) begin
            @(negedge mdc); phy_bit = phy_regs[hdr[4:0]][i];
          end
          @(negedge mdc); phy_drv = 1'b0; phy_bit = 1'b1;
        end
      end
    end
  end

  // ---------------- scoreboard ----------------
  typedef struct { logic [15:0] exp; string tag; } sb_item_t;
  sb_item_t sb_q[$];
  event sb_ev;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  initial forever begin
    @(sb_ev);
    while (sb_q.size() > 0) begin
      sb_item_t it;
      it = sb_q.pop_front();
      chk(it.tag, {16'h0, rdata}, {16'h0, it.exp});
    end
  end

  task automatic host_load(input int off, output logic [15:0] val);
    @(negedge clk); addr_wr = 1'b1; addr = {1'b0, 31'(off)};
    @(negedge clk); addr_wr = 1'b0;
    val = rdata;
  endtask

  task automatic expect_reg(input int off, input logic [15:0] exp, input string tag);
    logic [15:0] v;
    host_load(off, v);
    sb_q.push_back('{exp: exp, tag: tag});
    ->sb_ev;
    @(negedge clk);
  endtask

  task automatic host_store(input int off, input logic [15:0] val);
    @(negedge clk); wdata_wr = 1'b1; wdata = val;
    @(negedge clk); wdata_wr = 1'b0; addr_wr = 1'b1; addr = {1'b1, 31'(off)};
    @(negedge clk); addr_wr = 1'b0;
  endtask

  task automatic wait_idle();
    logic [15:0] v;
    for (int i = 0; i < 2000; i++) begin
      host_load('h14, v);
      if (v[14]) return;
    end
    chk("R5 finished flag never returned", 0, 1);
  endtask

  task automatic start_cmd(input logic [15:0] cmd);
    @(negedge clk); rises = 0; oe_rises = 0;
    host_store('h14, cmd);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int t0, t1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 mdc after reset", {31'h0, mdc}, 0);
    chk("R1 mdio_oe after reset", {31'h0, mdio_oe}, 0);
    expect_reg('h14, 16'h4000, "R1 R4 command reg after reset");
    expect_reg('h16, 16'h0000, "R1 data reg after reset");
    // R2 R3 indirect access
    host_store('h16, 16'hA5C3);
    expect_reg('h16, 16'hA5C3, "R2 R3 data reg store/load");
    expect_reg('h08, 16'h0000, "R2 unmapped offset");
    // write frame, phy 5 reg 9
    start_cmd(16'h2509);
    expect_reg('h14, 16'h2509, "R4 R5 fields with finished clear");
    // R7 mdc period
    @(posedge mdc); t0 = $time;
    @(posedge mdc); t1 = $time;
    chk("R7 mdc period ns", 32'(t1 - t0), 32'(2 * DH * 10));
    // R9 collisions while busy
    host_store('h14, 16'h0113);
    host_store('h16, 16'h1111);
    wait_idle();
    expect_reg('h14, 16'h6509, "R9 R5 command kept, finished set");
    expect_reg('h16, 16'hA5C3, "R9 data reg kept");
    chk("R6 preamble ones", 32'(last_pre), 32);
    chk("R6 write opcode", {30'h0, last_op}, 32'h1);
    chk("R6 phy field", {27'h0, last_phy}, 5);
    chk("R6 reg field", {27'h0, last_reg}, 9);
    chk("R6 write turnaround", {30'h0, last_ta}, 32'h2);
    chk("R10 write data on wire", {16'h0, last_wdata}, 32'hA5C3);
    chk("R6 rising edges per frame", 32'(rises), 64);
    chk("R6 driven rises on write", 32'(oe_rises), 64);
    // read back reg 9
    host_store('h16, 16'h0000);
    start_cmd(16'h0509);
    wait_idle();
    chk("R6 read opcode", {30'h0, last_op}, 32'h2);
    chk("R8 driven rises on read", 32'(oe_rises), 46);
    expect_reg('h16, 16'hA5C3, "R8 read captures phy word");
    expect_reg('h14, 16'h4509, "R4 read command readback");
    // write reg 31 then read back
    host_store('h16, 16'h0001);
    start_cmd(16'h251F);
    wait_idle();
    chk("R10 low-bit data on wire", {16'h0, last_wdata}, 32'h0001);
    host_store('h16, 16'h7E00);
    start_cmd(16'h051F);
    wait_idle();
    expect_reg('h16, 16'h0001, "R8 lsb position");
    start_cmd(16'h0500);
    wait_idle();
    expect_reg('h16, 16'h8000, "R8 msb first");
    // absent phy
    start_cmd(16'h0702);
    wait_idle();
    expect_reg('h16, 16'hFFFF, "R8 absent phy reads pull-up");
    chk("R7 mdc idle low", {31'h0, mdc}, 0);
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule